// File: doc/BRIEF.md
# Inclusive Snoop Filter Directory

This block is a presence directory for a coherent interconnect. It is set-associative, and each entry holds a line tag and one presence bit for each caching master. A coherent request looks up its line. If no master holds the line, the request goes to memory and no master is snooped. If some masters hold the line, only those masters are snooped.

Presence bits change on every coherent request. A shared read adds the requester to the holders. A unique request leaves the requester as the only holder. An explicit clean-evict notification clears one master's bit. When the last bit of an entry clears, the entry is freed.

The directory is inclusive. When a miss finds its set full, an entry is taken from a per-set round-robin pointer and its holders receive a back-invalidate. The back-invalidate is held at the outputs until it is acknowledged. Lookups to that set stall until then. Requests whose shareability domain is non-shareable bypass the directory completely. Data movement and memory access are handled elsewhere.

Top module: `snoop_filter_dir`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `binv_valid` are 0, and every entry is empty, so the first lookup of any line misses.
- R2: A request with `req_dom == 2'b00` (non-shareable) is answered with `rsp_snoop_mask == 0` and `rsp_to_mem == 1`, and leaves the directory unchanged.
- R3: A shareable lookup that misses, or that finds no holder other than the requester, answers `rsp_snoop_mask == 0` and `rsp_to_mem == 1`. On a miss, the requester is recorded as the line's holder.
- R4: A shareable request with `req_uniq == 0` (shared read) that hits answers a mask of exactly the current holders other than the requester. It then adds the requester's bit and keeps the other holders. Master `m` is bit `m` of every mask.
- R5: A request with `req_uniq == 1` (unique) that hits snoops every holder except the requester, and afterwards the requester is the sole holder.
- R6: An eviction notice (`evict_valid`, `evict_addr`, `evict_id`) clears that master's bit in the matching entry. An entry with no bits left is free and misses on its next lookup.
- R7: When an eviction notice and a request arrive in the same cycle, the request's lookup sees the directory with the eviction already applied.
- R8: A miss into a full set replaces the way given by that set's round-robin pointer (way 0 first, then way 1, and so on), and the pointer advances. In the next cycle `binv_valid` rises, with `binv_addr` equal to the victim's line address and `binv_mask` equal to its holders.
- R9: `binv_valid`, `binv_addr` and `binv_mask` hold until a cycle with `binv_done == 1`. While they are held, `req_ready` is 0 for requests to the victim's set and for requests that would need a new victim. Requests to other sets that hit or find a free way proceed.
- R10: A response (`rsp_valid` with its mask and memory flag) appears exactly one cycle after a request is accepted (`req_valid && req_ready`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Coherent request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_addr | input | ADDR_W | Line address (low bits select the set) |
| req_id | input | ID_W | Requesting master |
| req_uniq | input | 1 | 0 = shared read, 1 = unique request |
| req_dom | input | 2 | Shareability domain, 00 = non-shareable |
| evict_valid | input | 1 | Clean-evict notification present |
| evict_addr | input | ADDR_W | Line being dropped |
| evict_id | input | ID_W | Master dropping the line |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_snoop_mask | output | NM | Masters to snoop |
| rsp_to_mem | output | 1 | No snoop needed, go to memory |
| binv_valid | output | 1 | Back-invalidate pending |
| binv_addr | output | ADDR_W | Line to back-invalidate |
| binv_mask | output | NM | Masters to back-invalidate |
| binv_done | input | 1 | Back-invalidate completed |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clean-evict notice and a lookup of the same line. The bench sends both in one cycle, with the last holder evicting while another master requests the line. A correct directory reports a miss that goes to memory, not a snoop of the evicting master. The second pair is a pending back-invalidate and a new request: the bench checks that `req_ready` drops for the victim's set and that a request to an empty set is still answered while the back-invalidate is held.

// File: rtl/sf_pkg.sv
// Shared definitions for the snoop filter directory.
// Assumes: the request class is one bit and the domain is a two-bit code.
package sf_pkg;
    typedef enum logic {
        CLS_SHARED = 1'b0,
        CLS_UNIQUE = 1'b1
    } req_class_e;

    localparam logic [1:0] DOM_NONSHARE = 2'b00;
endpackage

// File: rtl/sf_way_match.sv
// Tag compare for one set row: flags the ways that hit and the ways that are free.
// Assumes: an entry is valid exactly when its presence vector is nonzero.
module sf_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 10,
    parameter int NM    = 4
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [WAYS-1:0][NM-1:0]    row_pres,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic [WAYS-1:0]            free_vec
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        // hit: valid entry with an equal tag; free: no holders left
        assign hit_vec[g]  = (row_pres[g] != '0) && (row_tag[g] == tag);
        assign free_vec[g] = (row_pres[g] == '0);
    end
endmodule

// File: rtl/sf_victim_pick.sv
// Chooses the way to fill on a miss: the lowest free way, else the round-robin way.
// Assumes: rr_way is always below WAYS.
module sf_victim_pick #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  free_vec,
    input  logic [WAY_W-1:0] rr_way,
    output logic [WAY_W-1:0] way
);
    // priority scan from the top so the lowest free way wins
    always_comb begin
        way = rr_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (free_vec[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sf_rr_ptrs.sv
// One round-robin replacement pointer per set; advances when that set loses a victim.
// Assumes: SETS is a power of two so every set index is in range.
module sf_rr_ptrs #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way
);
    logic [WAY_W-1:0] ptr_q [SETS];

    // pointer update with wrap at the last way
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv) begin
            ptr_q[adv_set] <= (ptr_q[adv_set] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[adv_set] + 1'b1;
        end
    end

    assign rd_way = ptr_q[rd_set];
endmodule

// File: rtl/snoop_filter_dir.sv
// Inclusive set-associative presence directory that filters coherent snoops.
// Assumes: addresses are line addresses; the low SET_W bits select the set;
// one request and one eviction notice at most per cycle; the eviction is
// applied before the same-cycle lookup; only one back-invalidate outstanding.
module snoop_filter_dir #(
    parameter int ADDR_W = 12,
    parameter int NM     = 4,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    localparam int ID_W  = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_uniq,
    input  logic [1:0]        req_dom,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [ID_W-1:0]   evict_id,
    output logic              rsp_valid,
    output logic [NM-1:0]     rsp_snoop_mask,
    output logic              rsp_to_mem,
    output logic              binv_valid,
    output logic [ADDR_W-1:0] binv_addr,
    output logic [NM-1:0]     binv_mask,
    input  logic              binv_done
);
    import sf_pkg::*;

    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [NM-1:0]    pres_q [SETS][WAYS];

    logic [SET_W-1:0] req_set, ev_set, pend_set_q;
    logic [TAG_W-1:0] req_tag, ev_tag;
    logic [NM-1:0]    req_bit, ev_bit, others;
    logic [WAYS-1:0][TAG_W-1:0] row_tag;
    logic [WAYS-1:0][NM-1:0]    row_pres;
    logic [WAYS-1:0]  hit_vec, free_vec;
    logic [WAY_W-1:0] hit_way, alloc_way, rr_way;
    logic             hit, dom_ok, accept, lookup_go, need_victim, is_uniq;

    assign req_set = req_addr[SET_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:SET_W];
    assign ev_set  = evict_addr[SET_W-1:0];
    assign ev_tag  = evict_addr[ADDR_W-1:SET_W];
    assign req_bit = NM'(1) << req_id;
    assign ev_bit  = NM'(1) << evict_id;
    assign is_uniq = (req_class_e'(req_uniq) == CLS_UNIQUE);
    assign dom_ok  = (req_dom != DOM_NONSHARE);

    // read the request's set row with any same-cycle eviction folded in
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_tag[w]  = tag_q[req_set][w];
            row_pres[w] = pres_q[req_set][w];
            if (evict_valid && ev_set == req_set && tag_q[req_set][w] == ev_tag)
                row_pres[w] = pres_q[req_set][w] & ~ev_bit;
        end
    end

    sf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .NM(NM)) i_match (
        .row_tag(row_tag), .row_pres(row_pres), .tag(req_tag),
        .hit_vec(hit_vec), .free_vec(free_vec)
    );

    sf_rr_ptrs #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) i_rr (
        .clk(clk), .rst_n(rst_n), .adv(lookup_go && need_victim),
        .adv_set(req_set), .rd_set(req_set), .rd_way(rr_way)
    );

    sf_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) i_pick (
        .free_vec(free_vec), .rr_way(rr_way), .way(alloc_way)
    );

    // encode the hitting way (tags are unique within a set)
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit         = |hit_vec;
    assign others      = row_pres[hit_way] & ~req_bit;
    assign need_victim = dom_ok && !hit && (free_vec == '0);
    assign req_ready   = !binv_valid || (req_set != pend_set_q && !need_victim);
    assign accept      = req_valid && req_ready;
    assign lookup_go   = accept && dom_ok;

    // directory state: eviction clears first, the request's write follows and wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    pres_q[s][w] <= '0;
                    tag_q[s][w]  <= '0;
                end
            end
        end else begin
            if (evict_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (tag_q[ev_set][w] == ev_tag)
                        pres_q[ev_set][w] <= pres_q[ev_set][w] & ~ev_bit;
                end
            end
            if (lookup_go) begin
                if (hit) begin
                    pres_q[req_set][hit_way] <= is_uniq ? req_bit : (row_pres[hit_way] | req_bit);
                end else begin
                    tag_q[req_set][alloc_way]  <= req_tag;
                    pres_q[req_set][alloc_way] <= req_bit;
                end
            end
        end
    end

    // lookup response, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_snoop_mask <= '0;
            rsp_to_mem     <= 1'b0;
        end else begin
            rsp_valid      <= accept;
            rsp_snoop_mask <= (lookup_go && hit) ? others : '0;
            rsp_to_mem     <= !(lookup_go && hit && others != '0);
        end
    end

    // back-invalidate register, held until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            binv_valid <= 1'b0;
            binv_addr  <= '0;
            binv_mask  <= '0;
            pend_set_q <= '0;
        end else if (lookup_go && need_victim) begin
            binv_valid <= 1'b1;
            binv_addr  <= {row_tag[alloc_way], req_set};
            binv_mask  <= row_pres[alloc_way];
            pend_set_q <= req_set;
        end else if (binv_done) begin
            binv_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/snoop_filter_dir_chk.sv
// Protocol checker for snoop_filter_dir, attached by bind below.
// Assumes: same parameters as the checked instance.
module snoop_filter_dir_chk #(
    parameter int ADDR_W = 12,
    parameter int NM     = 4,
    parameter int SETS   = 4,
    localparam int ID_W  = (NM > 1) ? $clog2(NM) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ID_W-1:0]   req_id,
    input logic [1:0]        req_dom,
    input logic              rsp_valid,
    input logic [NM-1:0]     rsp_snoop_mask,
    input logic              rsp_to_mem,
    input logic              binv_valid,
    input logic [ADDR_W-1:0] binv_addr,
    input logic [NM-1:0]     binv_mask,
    input logic              binv_done
);
    a_r10_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    a_r10_no_rsp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    a_r2_bypass_goes_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_dom == 2'b00) |=> (rsp_to_mem && rsp_snoop_mask == '0));
    a_r4_requester_not_snooped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (((rsp_snoop_mask >> $past(req_id)) & NM'(1)) == '0));
    a_r3_mem_iff_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_to_mem == (rsp_snoop_mask == '0)));
    a_r9_binv_held: assert property (@(posedge clk) disable iff (!rst_n)
        (binv_valid && !binv_done) |=> (binv_valid && $stable(binv_addr) && $stable(binv_mask)));
    a_r9_same_set_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (binv_valid && req_addr[SET_W-1:0] == binv_addr[SET_W-1:0]) |-> !req_ready);
    a_r8_victim_has_holders: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(binv_valid) |-> (binv_mask != '0));
endmodule

bind snoop_filter_dir snoop_filter_dir_chk #(.ADDR_W(ADDR_W), .NM(NM), .SETS(SETS)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_id(req_id), .req_dom(req_dom),
    .rsp_valid(rsp_valid), .rsp_snoop_mask(rsp_snoop_mask), .rsp_to_mem(rsp_to_mem),
    .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_mask(binv_mask),
    .binv_done(binv_done)
);

// File: tb/test_snoop_filter_dir.sv
// Scoreboard bench: the driver queues expected lookup results, the monitor compares them.
module test_snoop_filter_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_uniq = 1'b0, evict_valid = 1'b0, binv_done = 1'b0;
    logic [11:0] req_addr = '0, evict_addr = '0;
    logic [1:0]  req_id = '0, evict_id = '0, req_dom = 2'b01;
    logic        req_ready, rsp_valid, rsp_to_mem, binv_valid;
    logic [3:0]  rsp_snoop_mask, binv_mask;
    logic [11:0] binv_addr;

    int checks = 0, fails = 0;
    logic [3:0] q_mask[$];
    logic       q_mem[$];
    string      q_req[$];

    always #10 clk = ~clk;

    snoop_filter_dir i_snoop_filter_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_id(req_id), .req_uniq(req_uniq), .req_dom(req_dom),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_id(evict_id),
        .rsp_valid(rsp_valid), .rsp_snoop_mask(rsp_snoop_mask), .rsp_to_mem(rsp_to_mem),
        .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_mask(binv_mask),
        .binv_done(binv_done)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // monitor: pop one expected result per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_mask.size() == 0) begin
                check(1'b0, "R10 unexpected response", 1, 0);
            end else begin
                automatic logic [3:0] em = q_mask.pop_front();
                automatic logic emem = q_mem.pop_front();
                automatic string rq = q_req.pop_front();
                check(rsp_snoop_mask == em, {rq, " mask"}, rsp_snoop_mask, em);
                check(rsp_to_mem == emem, {rq, " to_mem"}, rsp_to_mem, emem);
            end
        end
    end

    // driver: queue the expectation, present the request until accepted
    task automatic issue(input logic [11:0] a, input logic [1:0] id, input logic uq,
                         input logic [1:0] dom, input logic [3:0] em, input logic emem,
                         input string rq, input logic ev = 1'b0,
                         input logic [11:0] ea = '0, input logic [1:0] eid = '0);
        q_mask.push_back(em);
        q_mem.push_back(emem);
        q_req.push_back(rq);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_id = id; req_uniq = uq; req_dom = dom;
        evict_valid = ev; evict_addr = ea; evict_id = eid;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0; evict_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b1, "R10 response one cycle after accept", rsp_valid, 1);
    endtask

    task automatic evict(input logic [11:0] a, input logic [1:0] id);
        @(negedge clk);
        evict_valid = 1'b1; evict_addr = a; evict_id = id;
        @(posedge clk);
        #1;
        evict_valid = 1'b0;
    endtask

    task automatic probe_stall(input logic [11:0] a, input logic [1:0] id, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_id = id; req_uniq = 1'b0; req_dom = 2'b01;
        #1;
        check(req_ready == 1'b0, rq, req_ready, 0);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic ack_binv;
        @(negedge clk);
        binv_done = 1'b1;
        @(posedge clk);
        #1;
        binv_done = 1'b0;
        @(negedge clk);
        check(binv_valid == 1'b0, "R9 back-invalidate drops after done", binv_valid, 0);
    endtask

    task automatic expect_binv(input logic [11:0] a, input logic [3:0] m, input string rq);
        check(binv_valid == 1'b1, {rq, " valid"}, binv_valid, 1);
        check(binv_addr == a, {rq, " addr"}, binv_addr, a);
        check(binv_mask == m, {rq, " mask"}, binv_mask, m);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        check(binv_valid == 1'b0, "R1 no back-invalidate after reset", binv_valid, 0);

        // line 0x010 (set 0, tag 4)
        issue(12'h010, 2'd0, 1'b0, 2'b01, 4'b0000, 1'b1, "R1/R3 first lookup misses");
        issue(12'h010, 2'd1, 1'b0, 2'b01, 4'b0001, 1'b0, "R4 shared hit snoops holder");
        issue(12'h010, 2'd2, 1'b0, 2'b00, 4'b0000, 1'b1, "R2 non-shareable bypass");
        issue(12'h010, 2'd3, 1'b0, 2'b10, 4'b0011, 1'b0, "R2/R4 bypass left directory unchanged");
        issue(12'h010, 2'd1, 1'b1, 2'b01, 4'b1001, 1'b0, "R5 unique snoops all others");
        issue(12'h010, 2'd0, 1'b0, 2'b01, 4'b0010, 1'b0, "R5 requester became sole holder");
        issue(12'h010, 2'd0, 1'b0, 2'b01, 4'b0010, 1'b0, "R3 own-line lookup snoops only others");
        evict(12'h010, 2'd1);
        issue(12'h010, 2'd2, 1'b0, 2'b11, 4'b0001, 1'b0, "R6 evict cleared holder bit");
        evict(12'h010, 2'd0);
        evict(12'h010, 2'd2);
        issue(12'h010, 2'd3, 1'b0, 2'b01, 4'b0000, 1'b1, "R6 emptied entry misses");
        // same-cycle evict of the last holder (m3) and request by m1
        issue(12'h010, 2'd1, 1'b0, 2'b01, 4'b0000, 1'b1, "R7 lookup sees same-cycle evict",
              1'b1, 12'h010, 2'd3);

        // fill set 0 and overflow it
        issue(12'h014, 2'd2, 1'b0, 2'b01, 4'b0000, 1'b1, "R3 fill second way");
        issue(12'h018, 2'd3, 1'b0, 2'b01, 4'b0000, 1'b1, "R8 overflow miss");
        expect_binv(12'h010, 4'b0010, "R8 victim is way 0 entry");
        probe_stall(12'h014, 2'd0, "R9 same-set lookup stalls");
        issue(12'h011, 2'd0, 1'b0, 2'b01, 4'b0000, 1'b1, "R9 other set proceeds");
        check(binv_valid == 1'b1, "R9 back-invalidate still held", binv_valid, 1);
        check(binv_addr == 12'h010, "R9 back-invalidate address stable", binv_addr, 12'h010);
        ack_binv();
        issue(12'h014, 2'd0, 1'b0, 2'b01, 4'b0100, 1'b0, "R8 non-victim way kept");
        issue(12'h01C, 2'd1, 1'b0, 2'b01, 4'b0000, 1'b1, "R8 second overflow miss");
        expect_binv(12'h014, 4'b0101, "R8 round-robin moved to way 1");
        ack_binv();
        issue(12'h010, 2'd0, 1'b0, 2'b01, 4'b0000, 1'b1, "R8 victimised line now misses");
        expect_binv(12'h018, 4'b1000, "R8 round-robin wrapped to way 0");
        ack_binv();

        repeat (3) @(negedge clk);
        check(q_mask.size() == 0, "R10 all responses received", q_mask.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule